// File: doc/BRIEF.md
# Interrupt Pacing Controller

The block merges per-channel interrupt requests into one receive interrupt line and one transmit interrupt line towards the CPU. Each direction has eight pending inputs and an eight-bit channel enable mask. It also has an upper limit on the number of interrupt pulses delivered in each one-millisecond pacing window. The window is built from a prescaled peripheral clock. A prescale value of the number of clock periods per 4 µs gives a 1 ms window of 250 ticks.

With pacing switched off for a direction, the enabled pending lines go straight to the output as a level. With pacing on, each new enabled request becomes a one-cycle pulse while the window's quota lasts. A request that arrives after the quota is used up is held. It is issued as the next window opens if its channel is still pending. A small register port sets the prescale value, the enables, the ceilings and the pacing switches, and it reports the per-channel status.

Top module: `irq_pacer`

## Requirements
- R1: The base tick recurs every max(P,1) clock cycles, where P is control register bits [10:0]. A pacing window is 250 ticks, and the first window starts when reset is released.
- R2: A channel whose enable bit is 0 has no effect on its direction's interrupt output or its status bit, whatever its pending line does.
- R3: Address 5 reads the receive status and address 6 the transmit status. Bit n is channel n pending AND enabled. Writes to these addresses change nothing.
- R4: With a direction's pacing bit at 0, its interrupt output equals the OR of its enabled pending lines in the same cycle.
- R5: With pacing on, a rising edge on any enabled pending line causes a one-cycle pulse in the next cycle, as long as the current window's quota is not used up.
- R6: With pacing on, no more pulses than the ceiling are issued within one window.
- R7: A held request whose channel is still enabled and pending is issued as a pulse in the first cycle of the next window.
- R8: A ceiling of 0 behaves as a ceiling of 1.
- R9: A held request is dropped once none of the enabled pending lines of its direction is high.
- R10: All registers reset to 0. The map is: 0 control (bits [10:0] prescale, bit 16 receive pacing, bit 17 transmit pacing), 1 receive enables, 2 transmit enables, 3 receive ceiling, 4 transmit ceiling. The written values read back.
- R11: The two directions are independent. Each has its own enables, ceiling, pacing bit and pulse count, and they share only the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_pend_i | input | 8 | Receive pending lines, one per channel |
| tx_pend_i | input | 8 | Transmit pending lines, one per channel |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| rx_irq_o | output | 1 | Combined receive interrupt |
| tx_irq_o | output | 1 | Combined transmit interrupt |

## Verification
The assertions check several properties on every cycle: a direction that has used its quota stays silent until the window rolls over; a disabled or idle direction never pulses; a held request fires right after the window boundary; and ticks keep their spacing. Other properties show only in the bench's scenarios, because they need a cycle-accurate reference for the window phase. These are the per-window pulse count under heavy random toggling, the ceiling-of-zero case, the dropping of stale held requests, the independence of the two directions, and the register map.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;
  localparam int unsigned CTRL_RX_PACE_BIT = 16;
  localparam int unsigned CTRL_TX_PACE_BIT = 17;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_RX_EN   = 3'd1,
    A_TX_EN   = 3'd2,
    A_RX_CEIL = 3'd3,
    A_TX_CEIL = 3'd4,
    A_RX_STAT = 3'd5,
    A_TX_STAT = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_pacer_tick.sv
module irq_pacer_tick #(
  parameter int unsigned PRESC_W       = 11,
  parameter int unsigned TICKS_PER_WIN = 250
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o,
  output logic               win_roll_o
);
  localparam int unsigned WIN_W = $clog2(TICKS_PER_WIN + 1);

  logic [PRESC_W-1:0] pcnt_q, presc_eff;
  logic [WIN_W-1:0]   wcnt_q;
  logic               last_tick;

  assign presc_eff  = (presc_i == '0) ? PRESC_W'(1) : presc_i;
  // >= keeps the counter from running away when the prescale is lowered
  assign tick_o     = pcnt_q >= presc_eff - PRESC_W'(1);
  assign last_tick  = wcnt_q == WIN_W'(TICKS_PER_WIN - 1);
  assign win_roll_o = tick_o && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      pcnt_q <= tick_o ? '0 : pcnt_q + PRESC_W'(1);
      if (tick_o) wcnt_q <= last_tick ? '0 : wcnt_q + WIN_W'(1);
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || presc_eff == PRESC_W'(1)));
endmodule

// File: rtl/irq_pacer_dir.sv
module irq_pacer_dir #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CEIL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              pace_en_i,
  input  logic [CEIL_W-1:0] ceil_i,
  input  logic              win_roll_i,
  output logic [NUM_CH-1:0] stat_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] masked, masked_q;
  logic              any, new_req, want, fire, req_q, pulse_q;
  logic [CEIL_W-1:0] ceil_eff, cnt_q, cnt_eff;

  assign masked   = pend_i & en_i;
  assign any      = |masked;
  assign new_req  = |(masked & ~masked_q);
  assign ceil_eff = (ceil_i == '0) ? CEIL_W'(1) : ceil_i;
  assign cnt_eff  = win_roll_i ? '0 : cnt_q;
  assign want     = (req_q || new_req) && any;
  assign fire     = pace_en_i && want && (cnt_eff < ceil_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masked_q <= '0;
      cnt_q    <= '0;
      req_q    <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      masked_q <= masked;
      if (!pace_en_i) begin
        cnt_q   <= '0;
        req_q   <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_eff + {{(CEIL_W-1){1'b0}}, fire};
        req_q   <= want && !fire;
        pulse_q <= fire;
      end
    end
  end

  assign stat_o = masked;
  assign irq_o  = pace_en_i ? pulse_q : any;

  assert_quota_spent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace_en_i && !win_roll_i && cnt_q >= ceil_eff) |=> !pulse_q);
  assert_idle_no_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace_en_i && !any) |=> !pulse_q);
  assert_held_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace_en_i && req_q && any && win_roll_i) |=> pulse_q);
  assert_passthru_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pace_en_i && !any) |-> !irq_o);
endmodule

// File: rtl/irq_pacer_regs.sv
module irq_pacer_regs
  import irq_pacer_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned PRESC_W = 11,
  parameter int unsigned CEIL_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         addr_i,
  input  logic               wr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_CH-1:0]  rx_stat_i,
  input  logic [NUM_CH-1:0]  tx_stat_i,
  output logic [PRESC_W-1:0] presc_o,
  output logic               rx_pace_o,
  output logic               tx_pace_o,
  output logic [NUM_CH-1:0]  rx_en_o,
  output logic [NUM_CH-1:0]  tx_en_o,
  output logic [CEIL_W-1:0]  rx_ceil_o,
  output logic [CEIL_W-1:0]  tx_ceil_o
);
  reg_addr_e addr;
  logic      unused_wdata;

  assign addr         = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_o   <= '0;
      rx_pace_o <= 1'b0;
      tx_pace_o <= 1'b0;
      rx_en_o   <= '0;
      tx_en_o   <= '0;
      rx_ceil_o <= '0;
      tx_ceil_o <= '0;
    end else if (wr_i) begin
      case (addr)
        A_CTRL: begin
          presc_o   <= wdata_i[PRESC_W-1:0];
          rx_pace_o <= wdata_i[CTRL_RX_PACE_BIT];
          tx_pace_o <= wdata_i[CTRL_TX_PACE_BIT];
        end
        A_RX_EN:   rx_en_o   <= wdata_i[NUM_CH-1:0];
        A_TX_EN:   tx_en_o   <= wdata_i[NUM_CH-1:0];
        A_RX_CEIL: rx_ceil_o <= wdata_i[CEIL_W-1:0];
        A_TX_CEIL: tx_ceil_o <= wdata_i[CEIL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_CTRL: begin
        rdata_o[PRESC_W-1:0]      = presc_o;
        rdata_o[CTRL_RX_PACE_BIT] = rx_pace_o;
        rdata_o[CTRL_TX_PACE_BIT] = tx_pace_o;
      end
      A_RX_EN:   rdata_o[NUM_CH-1:0] = rx_en_o;
      A_TX_EN:   rdata_o[NUM_CH-1:0] = tx_en_o;
      A_RX_CEIL: rdata_o[CEIL_W-1:0] = rx_ceil_o;
      A_TX_CEIL: rdata_o[CEIL_W-1:0] = tx_ceil_o;
      A_RX_STAT: rdata_o[NUM_CH-1:0] = rx_stat_i;
      A_TX_STAT: rdata_o[NUM_CH-1:0] = tx_stat_i;
      default: ;
    endcase
  end

  assert_en_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr == A_RX_EN) |=> rx_en_o == $past(wdata_i[NUM_CH-1:0]));
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int unsigned NUM_CH        = 8,
  parameter int unsigned PRESC_W       = 11,
  parameter int unsigned CEIL_W        = 8,
  parameter int unsigned TICKS_PER_WIN = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] rx_pend_i,
  input  logic [NUM_CH-1:0] tx_pend_i,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  localparam int unsigned NUM_DIR = 2;

  logic [PRESC_W-1:0]              presc;
  logic                            tick, win_roll;
  logic [NUM_DIR-1:0][NUM_CH-1:0]  pend_a, en_a, stat_a;
  logic [NUM_DIR-1:0][CEIL_W-1:0]  ceil_a;
  logic [NUM_DIR-1:0]              pace_a, irq_a;
  logic                            unused_tick;

  assign unused_tick = tick;
  assign pend_a[0]   = rx_pend_i;
  assign pend_a[1]   = tx_pend_i;

  irq_pacer_regs #(.NUM_CH(NUM_CH), .PRESC_W(PRESC_W), .CEIL_W(CEIL_W)) regs_i (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .rx_stat_i(stat_a[0]), .tx_stat_i(stat_a[1]),
    .presc_o(presc), .rx_pace_o(pace_a[0]), .tx_pace_o(pace_a[1]),
    .rx_en_o(en_a[0]), .tx_en_o(en_a[1]),
    .rx_ceil_o(ceil_a[0]), .tx_ceil_o(ceil_a[1])
  );

  irq_pacer_tick #(.PRESC_W(PRESC_W), .TICKS_PER_WIN(TICKS_PER_WIN)) tick_i (
    .clk_i, .rst_ni, .presc_i(presc), .tick_o(tick), .win_roll_o(win_roll)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    irq_pacer_dir #(.NUM_CH(NUM_CH), .CEIL_W(CEIL_W)) dir_i (
      .clk_i, .rst_ni,
      .pend_i(pend_a[d]), .en_i(en_a[d]), .pace_en_i(pace_a[d]),
      .ceil_i(ceil_a[d]), .win_roll_i(win_roll),
      .stat_o(stat_a[d]), .irq_o(irq_a[d])
    );
  end

  assign rx_irq_o = irq_a[0];
  assign tx_irq_o = irq_a[1];
endmodule

// File: tb/irq_pacer_tb_top.sv
module irq_pacer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_pend = '0, tx_pend = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_irq, tx_irq;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R10 reset";
  int    flip_rate = 8;

  always #2 clk = ~clk;

  irq_pacer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_pend_i(rx_pend), .tx_pend_i(tx_pend),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  // reference model state
  int       m_presc, m_pc, m_wc;
  bit [7:0] m_en [2];
  int       m_ceil [2];
  bit       m_pace [2];
  bit [7:0] m_mq [2];
  int       m_cnt [2];
  bit       m_req [2], m_pulse [2], m_skip [2];
  int       d_cnt [2];

  function automatic int ceil_eff(int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      finish_run();
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_presc = 0; m_pc = 0; m_wc = 0;
      for (int d = 0; d < 2; d++) begin
        m_en[d] = '0; m_ceil[d] = 0; m_pace[d] = 0; m_mq[d] = '0;
        m_cnt[d] = 0; m_req[d] = 0; m_pulse[d] = 0; m_skip[d] = 1; d_cnt[d] = 0;
      end
    end else begin
      int  eff;
      bit  tick, roll;
      eff  = (m_presc == 0) ? 1 : m_presc;
      tick = m_pc >= eff - 1;
      roll = tick && m_wc == 249;
      for (int d = 0; d < 2; d++) begin
        bit [7:0] mk;
        bit       any, edg, want, fire;
        int       ce, cn;
        mk   = (d == 0 ? rx_pend : tx_pend) & m_en[d];
        any  = |mk;
        edg  = |(mk & ~m_mq[d]);
        ce   = ceil_eff(m_ceil[d]);
        cn   = roll ? 0 : m_cnt[d];
        want = (m_req[d] || edg) && any;
        fire = m_pace[d] && want && (cn < ce);
        if (roll) begin
          if (m_pace[d] && !m_skip[d])
            chk(d_cnt[d] <= ce, d == 0 ? "R6 rx window count" : "R6 tx window count", d_cnt[d], ce);
          d_cnt[d] = 0;
          m_skip[d] = 0;
        end
        m_mq[d] = mk;
        if (!m_pace[d]) begin
          m_cnt[d] = 0; m_req[d] = 0; m_pulse[d] = 0;
        end else begin
          m_cnt[d] = cn + int'(fire); m_req[d] = want && !fire; m_pulse[d] = fire;
        end
      end
      m_pc = tick ? 0 : m_pc + 1;
      if (tick) m_wc = (m_wc == 249) ? 0 : m_wc + 1;
      if (wr) begin
        m_skip[0] = 1; m_skip[1] = 1;
        case (addr)
          3'd0: begin m_presc = int'(wdata[10:0]); m_pace[0] = wdata[16]; m_pace[1] = wdata[17]; end
          3'd1: m_en[0] = wdata[7:0];
          3'd2: m_en[1] = wdata[7:0];
          3'd3: m_ceil[0] = int'(wdata[7:0]);
          3'd4: m_ceil[1] = int'(wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  // output comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit er, et;
      er = m_pace[0] ? m_pulse[0] : |(rx_pend & m_en[0]);
      et = m_pace[1] ? m_pulse[1] : |(tx_pend & m_en[1]);
      chk(rx_irq == er, {phase, " rx_irq"}, int'(rx_irq), int'(er));
      chk(tx_irq == et, {phase, " tx_irq"}, int'(tx_irq), int'(et));
      if (m_pace[0] && rx_irq) d_cnt[0]++;
      if (m_pace[1] && tx_irq) d_cnt[1]++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rnd_step(bit [7:0] rx_mask, bit [7:0] tx_mask);
    step();
    for (int c = 0; c < 8; c++) begin
      if (rx_mask[c] && ($urandom % flip_rate) == 0) rx_pend[c] = ~rx_pend[c];
      if (tx_mask[c] && ($urandom % (flip_rate * 2)) == 0) tx_pend[c] = ~tx_pend[c];
    end
  endtask

  task automatic wr_reg(bit [2:0] a, bit [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(bit [2:0] a, bit [31:0] exp, string tag);
    addr = a;
    @(negedge clk);
    chk(rdata == exp, tag, int'(rdata), int'(exp));
    step();
  endtask

  task automatic run(int cycles, bit [7:0] rx_mask, bit [7:0] tx_mask);
    for (int i = 0; i < cycles; i++) rnd_step(rx_mask, tx_mask);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    @(negedge clk);
    chk(rx_irq == 0 && tx_irq == 0, "R10 irq after reset", int'({rx_irq, tx_irq}), 0);
    step();
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'h0, "R10 reset readback");
    // R10 register map readback
    wr_reg(3'd0, 32'h0003_0123);
    wr_reg(3'd1, 32'hFFFF_FFA5);
    wr_reg(3'd2, 32'h0000_005A);
    wr_reg(3'd3, 32'h0000_0107);
    wr_reg(3'd4, 32'h0000_0009);
    rd_chk(3'd0, 32'h0003_0123, "R10 ctrl readback");
    rd_chk(3'd1, 32'h0000_00A5, "R10 rx enable readback");
    rd_chk(3'd2, 32'h0000_005A, "R10 tx enable readback");
    rd_chk(3'd3, 32'h0000_0007, "R10 rx ceiling readback");
    rd_chk(3'd4, 32'h0000_0009, "R10 tx ceiling readback");
    // R3 status and ignored writes
    wr_reg(3'd0, 32'h0000_0002);
    rx_pend = 8'hFF; tx_pend = 8'h0F;
    step();
    rd_chk(3'd5, 32'h0000_00A5, "R3 rx status");
    rd_chk(3'd6, 32'h0000_000A, "R3 tx status");
    wr_reg(3'd5, 32'h0000_0000);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    rd_chk(3'd5, 32'h0000_00A5, "R3 rx status after write");
    rd_chk(3'd6, 32'h0000_000A, "R3 tx status after write");
    rd_chk(3'd1, 32'h0000_00A5, "R3 enables untouched by status write");

    phase = "R4 passthrough";
    wr_reg(3'd0, 32'h0000_0003);
    wr_reg(3'd1, 32'h0000_00FF);
    wr_reg(3'd2, 32'h0000_00C3);
    run(2000, 8'hFF, 8'hFF);

    phase = "R5 R6 paced";
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd4, 32'd5);
    wr_reg(3'd0, 32'h0003_0002);
    run(3000, 8'hFF, 8'hFF);

    phase = "R2 masked channels";
    wr_reg(3'd1, 32'h0000_000F);
    wr_reg(3'd2, 32'h0000_00F0);
    rx_pend = 8'h00; tx_pend = 8'h00;
    run(1500, 8'hF0, 8'h0F);
    rd_chk(3'd5, 32'h0, "R2 rx status of disabled channels");
    rd_chk(3'd6, 32'h0, "R2 tx status of disabled channels");

    phase = "R8 zero ceiling";
    wr_reg(3'd1, 32'h0000_00FF);
    wr_reg(3'd2, 32'h0000_00FF);
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd4, 32'd0);
    run(2000, 8'hFF, 8'hFF);

    phase = "R7 R9 held requests";
    flip_rate = 3;
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd4, 32'd2);
    run(2500, 8'hFF, 8'hFF);
    flip_rate = 40;
    run(2500, 8'h03, 8'h03);

    phase = "R1 prescale";
    flip_rate = 6;
    wr_reg(3'd0, 32'h0003_0007);
    run(6000, 8'hFF, 8'hFF);
    wr_reg(3'd0, 32'h0003_0000);
    run(1000, 8'hFF, 8'hFF);

    phase = "R11 independent directions";
    wr_reg(3'd0, 32'h0001_0001);
    wr_reg(3'd3, 32'd2);
    run(1500, 8'hFF, 8'hFF);
    wr_reg(3'd0, 32'h0002_0001);
    wr_reg(3'd4, 32'd4);
    run(1500, 8'hFF, 8'hFF);

    finish_run();
  end
endmodule